// File: doc/BRIEF.md
# Fan Failure Detector

This block decides, for each of several fans, whether the fan has stopped doing its job. It watches either a tachometer count, delivered as a new sample with a strobe whenever a measurement finishes, or a locked-rotor logic level that the fan drives while its rotor is stalled. A suspicious reading must last through a persistence window timed on a slow tick (one second at the intended 8192 Hz tick rate). In tachometer monitoring, that window must also be confirmed several times in a row before the fan is declared failed.

When a fan is declared failed, its fault flag is set and stays set, and a drive-removal request is raised for that fan. A shared active-low fail pin is driven as an open-drain pull-down enable whenever any unmasked fan has failed. Writing a new drive or count target for a fan, or pulsing its clear input, removes the fault and restarts monitoring. The rules for tachometer faults depend on the fan's control mode. In voltage mode a count above the limit is suspicious. In speed mode any of three readings is suspicious: the fan is too slow at full drive, the count is above twice the target, or the counter has saturated.

Top module: `fan_fail_detector`

## Requirements
- R1: After reset, every `fault_flag` and `drive_kill` bit is 0 and `fail_oe` is 0.
- R2: With `speed_mode`=0 and `lr_sel`=0, a sample is a fault reading exactly when `tach_cnt` is greater than `target`, both compared as unsigned integers.
- R3: With `speed_mode`=1 and `lr_sel`=0, a sample is a fault reading when `tach_cnt` > `target` while `drive_full`=1, or `tach_cnt` > 2×`target` (computed one bit wider), or `tach_cnt` is all ones (7FFh for 11-bit counts).
- R4: After a fault sample is captured on edge k, and with `tick` high on every edge, `fault_flag` rises on edge k + `PERSIST_TICKS`×`DETECTS` and not before. One detection is one full window of `PERSIST_TICKS` ticks.
- R5: A non-fault sample clears both the window timer and the count of consecutive detections, so the full time is needed again from the next fault sample.
- R6: With `lr_sel`=1 the fan is stalled while `lr_in` equals `lr_pol` (`lr_pol`=1 means active high). `fault_flag` rises `PERSIST_TICKS` ticks after the stalled level is first captured, with a single window. The opposite level never sets the flag.
- R7: `fault_flag` is sticky: later non-fault readings leave it set. `drive_kill` equals `fault_flag`.
- R8: A `tgt_wr` or `flag_clr` pulse for a fan clears that fan's flag on the next edge and restarts its monitoring. This holds even when the pulse lands on the edge that would have completed the final detection.
- R9: `fail_oe` is 1 exactly when some fan has `fault_flag`=1 and `fail_mask`=0 for that fan. Each fan's detection is independent of the other fans.
- R10: While `mon_en` is 0 for a fan, no reading for that fan can set its flag.
- R11: The window advances only on edges where `tick` is 1. Edges with `tick`=0 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Persistence time-base strobe |
| mon_en | input | NUM_FANS | Per-fan monitoring enable |
| speed_mode | input | NUM_FANS | 1 = speed (count-target) mode, 0 = voltage mode |
| lr_sel | input | NUM_FANS | 1 = locked-rotor monitoring, 0 = tachometer |
| lr_pol | input | NUM_FANS | Stalled level of the locked-rotor input |
| lr_in | input | NUM_FANS | Locked-rotor levels, synchronous |
| drive_full | input | NUM_FANS | Fan drive currently at full scale |
| sample_vld | input | NUM_FANS | New tachometer count present this cycle |
| tgt_wr | input | NUM_FANS | Pulse: new drive or count target written |
| flag_clr | input | NUM_FANS | Pulse: explicit fault clear |
| fail_mask | input | NUM_FANS | 1 hides that fan from `fail_oe` |
| tach_cnt | input | NUM_FANS×CNT_W | Packed tachometer counts, fan 0 in the low bits |
| target | input | NUM_FANS×CNT_W | Packed count targets or limits |
| fault_flag | output | NUM_FANS | Sticky failure flags |
| drive_kill | output | NUM_FANS | Request to remove fan drive |
| fail_oe | output | 1 | Pull-down enable for the open-drain fail pin |

## Verification
A clear can fall in the same cycle that the final detection window completes: the target write competes with the flag set. The bench holds a fault until one edge before the flag would rise, then pulses `tgt_wr` on exactly that edge, and expects the flag to stay 0 with the full time needed afterwards. A non-fault sample can also land one edge before a fault sample. The bench sends fault, good and fault samples back to back and expects the full persistence time counted from the last sample alone.

// File: rtl/fan_fail_detector.sv
module fan_fail_detector #(
  parameter int NUM_FANS      = 4,
  parameter int CNT_W         = 11,
  parameter int PERSIST_TICKS = 8192,
  parameter int DETECTS       = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [NUM_FANS-1:0]       mon_en,
  input  logic [NUM_FANS-1:0]       speed_mode,
  input  logic [NUM_FANS-1:0]       lr_sel,
  input  logic [NUM_FANS-1:0]       lr_pol,
  input  logic [NUM_FANS-1:0]       lr_in,
  input  logic [NUM_FANS-1:0]       drive_full,
  input  logic [NUM_FANS-1:0]       sample_vld,
  input  logic [NUM_FANS-1:0]       tgt_wr,
  input  logic [NUM_FANS-1:0]       flag_clr,
  input  logic [NUM_FANS-1:0]       fail_mask,
  input  logic [NUM_FANS*CNT_W-1:0] tach_cnt,
  input  logic [NUM_FANS*CNT_W-1:0] target,
  output logic [NUM_FANS-1:0]       fault_flag,
  output logic [NUM_FANS-1:0]       drive_kill,
  output logic                      fail_oe
);

  localparam int TW = $clog2(PERSIST_TICKS + 1);
  localparam int DW = $clog2(DETECTS + 1);
  localparam logic [TW-1:0] TMAX = TW'(PERSIST_TICKS - 1);
  localparam logic [DW-1:0] DMAX = DW'(DETECTS - 1);

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    logic [CNT_W-1:0] cnt, tgt;
    logic             over, over2, sat, tcond, lr_act, good, bad, last_det;
    logic             armed, flag_q;
    logic [TW-1:0]    timer;
    logic [DW-1:0]    det;

    assign cnt    = tach_cnt[g*CNT_W +: CNT_W];
    assign tgt    = target[g*CNT_W +: CNT_W];
    assign over   = cnt > tgt;
    assign over2  = {1'b0, cnt} > {tgt, 1'b0};
    assign sat    = &cnt;
    assign tcond  = speed_mode[g] ? ((over && drive_full[g]) || over2 || sat) : over;
    assign lr_act = lr_in[g] == lr_pol[g];
    assign good   = lr_sel[g] ? !lr_act : (sample_vld[g] && !tcond);
    assign bad    = lr_sel[g] ? lr_act  : (sample_vld[g] && tcond);
    assign last_det = lr_sel[g] ? 1'b1 : (det == DMAX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed  <= 1'b0;
        timer  <= '0;
        det    <= '0;
        flag_q <= 1'b0;
      end else if (!mon_en[g] || tgt_wr[g] || flag_clr[g]) begin
        armed <= 1'b0;
        timer <= '0;
        det   <= '0;
        if (tgt_wr[g] || flag_clr[g]) flag_q <= 1'b0;
      end else if (good) begin
        armed <= 1'b0;
        timer <= '0;
        det   <= '0;
      end else begin
        if (bad) armed <= 1'b1;
        if (armed && tick && !flag_q) begin
          if (timer == TMAX) begin
            timer <= '0;
            if (last_det) begin
              flag_q <= 1'b1;
              det    <= '0;
            end else begin
              det <= det + 1'b1;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
      end
    end

    assign fault_flag[g] = flag_q;
  end

  assign drive_kill = fault_flag;
  assign fail_oe    = |(fault_flag & ~fail_mask);

endmodule

// File: rtl/fan_fail_detector_chk.sv
module fan_fail_detector_chk #(
  parameter int NUM_FANS      = 4,
  parameter int CNT_W         = 11,
  parameter int PERSIST_TICKS = 8192,
  parameter int DETECTS       = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [NUM_FANS-1:0]       mon_en,
  input logic [NUM_FANS-1:0]       lr_sel,
  input logic [NUM_FANS-1:0]       lr_pol,
  input logic [NUM_FANS-1:0]       lr_in,
  input logic [NUM_FANS-1:0]       sample_vld,
  input logic [NUM_FANS-1:0]       tgt_wr,
  input logic [NUM_FANS-1:0]       flag_clr,
  input logic [NUM_FANS-1:0]       fail_mask,
  input logic [NUM_FANS*CNT_W-1:0] tach_cnt,
  input logic [NUM_FANS*CNT_W-1:0] target,
  input logic [NUM_FANS-1:0]       fault_flag,
  input logic                      fail_oe
);
  for (genvar g = 0; g < NUM_FANS; g++) begin : g_chk
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_wr[g] || flag_clr[g]) |=> !fault_flag[g]);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag[g] && !tgt_wr[g] && !flag_clr[g]) |=> fault_flag[g]);
    p_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag[g]) |-> $past(tick));
    p_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag[g]) |-> $past(mon_en[g]));
    p_good_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en[g] && !lr_sel[g] && sample_vld[g] && !fault_flag[g] &&
       tach_cnt[g*CNT_W +: CNT_W] <= target[g*CNT_W +: CNT_W] &&
       !(&tach_cnt[g*CNT_W +: CNT_W])) |=> !fault_flag[g]);
    p_lr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en[g] && lr_sel[g] && lr_in[g] != lr_pol[g] && !fault_flag[g]) |=> !fault_flag[g]);
    p_fail_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag[g] && !fail_mask[g]) |-> fail_oe);
  end
endmodule

bind fan_fail_detector fan_fail_detector_chk #(
  .NUM_FANS(NUM_FANS), .CNT_W(CNT_W), .PERSIST_TICKS(PERSIST_TICKS), .DETECTS(DETECTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mon_en(mon_en), .lr_sel(lr_sel),
  .lr_pol(lr_pol), .lr_in(lr_in), .sample_vld(sample_vld), .tgt_wr(tgt_wr),
  .flag_clr(flag_clr), .fail_mask(fail_mask), .tach_cnt(tach_cnt), .target(target),
  .fault_flag(fault_flag), .fail_oe(fail_oe)
);

// File: tb/fan_fail_detector_tb.sv
module fan_fail_detector_tb;
  localparam int PER = 10;
  localparam int NF  = 2;
  localparam int CW  = 11;
  localparam int PT  = 4;
  localparam int DT  = 4;
  localparam int FULL = PT * DT;

  logic clk = 0, rst_n = 0, tick = 1;
  logic [NF-1:0] mon_en = '1, speed_mode = '0, lr_sel = '0, lr_pol = '0, lr_in = '0;
  logic [NF-1:0] drive_full = '0, sample_vld = '0, tgt_wr = '0, flag_clr = '0, fail_mask = '0;
  logic [NF*CW-1:0] tach_cnt = '0, target = '0;
  logic [NF-1:0] fault_flag, drive_kill;
  logic fail_oe;
  int n_chk = 0, n_fail = 0;

  fan_fail_detector #(.NUM_FANS(NF), .CNT_W(CW), .PERSIST_TICKS(PT), .DETECTS(DT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mon_en(mon_en), .speed_mode(speed_mode),
    .lr_sel(lr_sel), .lr_pol(lr_pol), .lr_in(lr_in), .drive_full(drive_full),
    .sample_vld(sample_vld), .tgt_wr(tgt_wr), .flag_clr(flag_clr), .fail_mask(fail_mask),
    .tach_cnt(tach_cnt), .target(target), .fault_flag(fault_flag), .drive_kill(drive_kill),
    .fail_oe(fail_oe));

  always #(PER/2) clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input int f, input int c);
    tach_cnt[f*CW +: CW] = CW'(c);
    sample_vld[f] = 1'b1;
    cyc(1);
    sample_vld[f] = 1'b0;
  endtask

  task automatic clear_tgt(input int f);
    tgt_wr[f] = 1'b1;
    cyc(1);
    tgt_wr[f] = 1'b0;
  endtask

  task automatic run_case(input int c, input int t, input bit exp, input string req);
    target[CW-1:0] = CW'(t);
    sample(0, c);
    cyc(FULL - 1);
    if (exp) chk({req, " R4 early"}, fault_flag[0], 0);
    cyc(1);
    chk(req, fault_flag[0], exp);
    chk({req, " R7 kill"}, drive_kill[0], exp);
    chk({req, " R9 pin"}, fail_oe, exp);
    if (exp) begin
      clear_tgt(0);
      chk("R8 target write", fault_flag[0], 0);
    end
  endtask

  initial begin
    #(PER * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int tl[8] = '{0, 1, 2, 5, 300, 1023, 1024, 2047};
    cyc(3);
    chk("R1 flag", fault_flag, 0);
    chk("R1 kill", drive_kill, 0);
    chk("R1 pin", fail_oe, 0);
    rst_n = 1;
    cyc(1);

    for (int m = 0; m < 3; m++) begin
      speed_mode[0] = (m != 0);
      drive_full[0] = (m == 2);
      for (int ti = 0; ti < 8; ti++) begin
        for (int k = 0; k < 6; k++) begin
          int t = tl[ti];
          int c;
          bit e;
          case (k)
            0: c = t - 1;
            1: c = t;
            2: c = t + 1;
            3: c = 2 * t;
            4: c = 2 * t + 1;
            default: c = 2047;
          endcase
          if (c < 0) c = 0;
          if (c > 2047) c = 2047;
          if (m == 0) e = (c > t);
          else e = ((c > t) && (m == 2)) || (c > 2 * t) || (c == 2047);
          run_case(c, t, e, (m == 0) ? "R2 voltage" : "R3 speed");
        end
      end
    end

    speed_mode[0] = 0;
    target[CW-1:0] = 100;
    sample(0, 200);
    cyc(2 * PT + 1);
    sample(0, 50);
    sample(0, 200);
    cyc(FULL - 1);
    chk("R5 restart early", fault_flag[0], 0);
    cyc(1);
    chk("R5 restart", fault_flag[0], 1);

    sample(0, 10);
    cyc(3);
    chk("R7 sticky", fault_flag[0], 1);
    flag_clr[0] = 1; cyc(1); flag_clr[0] = 0;
    chk("R8 flag_clr", fault_flag[0], 0);

    sample(0, 200);
    cyc(FULL - 1);
    tgt_wr[0] = 1; cyc(1); tgt_wr[0] = 0;
    chk("R8 clear wins", fault_flag[0], 0);
    cyc(FULL + 2);
    chk("R8 restarted", fault_flag[0], 0);

    tick = 0;
    sample(0, 200);
    for (int i = 0; i < 32; i++) begin
      tick = (i % 2 == 0);
      cyc(1);
      if (i == 29) chk("R11 half-rate early", fault_flag[0], 0);
      if (i == 30) chk("R11 half-rate", fault_flag[0], 1);
    end
    tick = 1;
    clear_tgt(0);

    mon_en[0] = 0;
    sample(0, 500);
    cyc(FULL + 4);
    chk("R10 disabled", fault_flag[0], 0);
    mon_en[0] = 1;

    for (int p = 0; p < 2; p++) begin
      lr_sel[0] = 1; lr_pol[0] = p[0]; lr_in[0] = ~p[0];
      cyc(FULL + 4);
      chk("R6 idle level", fault_flag[0], 0);
      lr_in[0] = p[0];
      cyc(1);
      cyc(PT - 1);
      chk("R6 early", fault_flag[0], 0);
      cyc(1);
      chk("R6 stalled", fault_flag[0], 1);
      lr_in[0] = ~p[0];
      clear_tgt(0);
      chk("R8 lr clear", fault_flag[0], 0);
    end
    lr_sel[0] = 0;

    fail_mask[1] = 1;
    target[CW +: CW] = 20;
    sample(1, 40);
    cyc(FULL);
    chk("R9 fan1 flag", fault_flag[1], 1);
    chk("R9 masked pin", fail_oe, 0);
    chk("R9 fan0 independent", fault_flag[0], 0);
    fail_mask[1] = 0;
    cyc(1);
    chk("R9 unmasked pin", fail_oe, 1);
    clear_tgt(1);
    chk("R9 pin released", fail_oe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule